// File: doc/BRIEF.md
# Receiver Event Interrupt Aggregator

This block collects event indications from a receiver datapath and turns them into sticky interrupt flags that a host can read and clear. There are three kinds of source. A paired source is a level status signal, such as a lock indicator. Its rising edge raises a "locked" flag and its falling edge raises a separate "lost" flag. A single-edge source is also a level signal, but it raises its flag only when it rises. A pulse source is a one-cycle strobe, for example a measurement-done or FIFO event, and it raises its flag directly.

A small word-wide register bus gives the host four things. It can read the sampled status levels, read the flags, clear flags by writing ones, and write the per-flag enable mask and a three-bit configuration word. The block drives one interrupt pin. The pin is asserted when any enabled flag is set and the global enable is on. The configuration word also selects the asserted level of the pin and whether it is driven push-pull or open-drain. The open-drain case uses a separate output-enable.

The flag vector has a fixed layout. Paired "locked" flags come first, then paired "lost" flags, then single-edge flags, then pulse flags.

Top module: `intagg_top`

## Requirements
- R1: Each flag, once set by its event, stays 1 until the host clears it. Flag bit layout with defaults NPAIR=5, NEDGE=6, NPULSE=10: bits 0-4 are the paired locked flags, bits 5-9 the paired lost flags, bits 10-15 the single-edge flags, and bits 16-25 the pulse flags.
- R2: A bus write to address 1 clears every flag whose write-data bit is 1. Write-data bits that are 0 leave their flags unchanged. If an event sets a flag in the same cycle that a write clears it, the flag ends up 1.
- R3: The pin is asserted when config bit 0 (global enable) is 1 and at least one flag is 1 with its enable bit (address 2) also 1. Otherwise the pin is deasserted.
- R4: The global enable affects only the pin. Flags keep being set and stay readable at address 1 while it is 0.
- R5: Config bit 1 selects the asserted pin level: 1 means asserted high, 0 means asserted low. The deasserted level is the inverse.
- R6: Config bit 2 selects the drive type. When it is 0 (push-pull), the output-enable is always 1. When it is 1 (open-drain), the output-enable is 1 with the asserted level while the pin is asserted, and 0 while it is deasserted.
- R7: For paired source i, a 0-to-1 change of its level sets locked flag i and a 1-to-0 change sets lost flag NPAIR+i.
- R8: A single-edge source sets its flag only on a 0-to-1 change. A falling level sets nothing.
- R9: A pulse source that is high in a cycle sets its flag in that cycle.
- R10: Reset clears the flags, the enable mask and the config word, so after reset the pin is push-pull, deasserted, and held high (inactive for active-low). The previous level sample also resets to 0, so a level source that is high when reset is released raises its rising-edge flag.
- R11: Reads return the following. Address 0 gives the sampled levels, paired sources in bits 0 to NPAIR-1 and single-edge sources above them. Address 1 gives the flags, address 2 the enables, and address 3 the config word in bits 2:0. Unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_pair_i | input | NPAIR | Paired lock/unlock status levels |
| lvl_edge_i | input | NEDGE | Rising-edge-only status levels |
| pulse_i | input | NPULSE | One-cycle event strobes |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for bus_addr_i (combinational) |
| irq_pin_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin output-enable |

## Verification
The hardest situation to reach from the ports is a new event and a host clear landing on the same flag in the same clock cycle. The stimulus for it holds a pulse source high during the very cycle that the bus writes a one to that flag's bit, then reads the flag back.

A second awkward case is a level source that is already high as reset is released. The bench holds a paired level high through reset and checks that only its locked flag appears.

The stimulus table also walks paired levels up and down, raises and drops a single-edge level, and mixes pulses with partial clears.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

    typedef enum logic [1:0] {
        ADDR_STAT = 2'd0,
        ADDR_FLAG = 2'd1,
        ADDR_ENA  = 2'd2,
        ADDR_CFG  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic od;   // bit 2: open-drain drive
        logic pol;  // bit 1: asserted high
        logic gie;  // bit 0: global pin enable
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/intagg_edge.sv
module intagg_edge #(
    parameter int NPAIR  = 5,
    parameter int NEDGE  = 6,
    parameter int NPULSE = 10,
    localparam int NLVL  = NPAIR + NEDGE,
    localparam int NFLAG = 2 * NPAIR + NEDGE + NPULSE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPAIR-1:0]  lvl_pair_i,
    input  logic [NEDGE-1:0]  lvl_edge_i,
    input  logic [NPULSE-1:0] pulse_i,
    output logic [NLVL-1:0]   lvl_q_o,
    output logic [NFLAG-1:0]  set_o
);

    logic [NLVL-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = {lvl_edge_i, lvl_pair_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign lvl_q_o = lvl_q;

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        assign set_o[i]         =  lvl_pair_i[i] & ~lvl_q[i];
        assign set_o[NPAIR + i] = ~lvl_pair_i[i] &  lvl_q[i];
    end

    for (genvar j = 0; j < NEDGE; j++) begin : g_edge
        assign set_o[2 * NPAIR + j] = lvl_edge_i[j] & ~lvl_q[NPAIR + j];
    end

    for (genvar k = 0; k < NPULSE; k++) begin : g_pulse
        assign set_o[2 * NPAIR + NEDGE + k] = pulse_i[k];
    end

endmodule

// File: rtl/intagg_pin.sv
module intagg_pin
    import intagg_pkg::*;
(
    input  logic pending_i,
    input  cfg_t cfg_i,
    output logic pin_o,
    output logic oe_o
);

    always_comb begin
        pin_o = pending_i ? cfg_i.pol : ~cfg_i.pol;
        oe_o  = cfg_i.od ? pending_i : 1'b1;
    end

endmodule

// File: rtl/intagg_top.sv
module intagg_top
    import intagg_pkg::*;
#(
    parameter int NPAIR  = 5,
    parameter int NEDGE  = 6,
    parameter int NPULSE = 10,
    parameter int DW     = 32,
    localparam int NLVL  = NPAIR + NEDGE,
    localparam int NFLAG = 2 * NPAIR + NEDGE + NPULSE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPAIR-1:0]  lvl_pair_i,
    input  logic [NEDGE-1:0]  lvl_edge_i,
    input  logic [NPULSE-1:0] pulse_i,
    input  logic [1:0]        bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              irq_pin_o,
    output logic              irq_oe_o
);

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic [NFLAG-1:0] ena;
        cfg_t             cfg;
    } state_t;

    state_t           st_d, st_q;
    logic [NLVL-1:0]  lvl_q;
    logic [NFLAG-1:0] set_ev;
    logic [NFLAG-1:0] clr_mask;
    logic [NFLAG-1:0] flags_q;
    cfg_t             cfg_q;
    logic             pending;
    logic             unused_wbits;
    reg_addr_e        addr;

    assign addr         = reg_addr_e'(bus_addr_i);
    assign unused_wbits = ^bus_wdata_i;

    intagg_edge #(
        .NPAIR (NPAIR),
        .NEDGE (NEDGE),
        .NPULSE(NPULSE)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_pair_i(lvl_pair_i),
        .lvl_edge_i(lvl_edge_i),
        .pulse_i   (pulse_i),
        .lvl_q_o   (lvl_q),
        .set_o     (set_ev)
    );

    always_comb begin
        st_d     = st_q;
        clr_mask = (bus_wr_i && addr == ADDR_FLAG) ? bus_wdata_i[NFLAG-1:0] : '0;
        st_d.flags = (st_q.flags & ~clr_mask) | set_ev;
        if (bus_wr_i && addr == ADDR_ENA) st_d.ena = bus_wdata_i[NFLAG-1:0];
        if (bus_wr_i && addr == ADDR_CFG) st_d.cfg = cfg_t'(bus_wdata_i[CFG_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;
    assign cfg_q   = st_q.cfg;
    assign pending = cfg_q.gie & (|(st_q.flags & st_q.ena));

    always_comb begin
        bus_rdata_o = '0;
        unique case (addr)
            ADDR_STAT: bus_rdata_o[NLVL-1:0]  = lvl_q;
            ADDR_FLAG: bus_rdata_o[NFLAG-1:0] = st_q.flags;
            ADDR_ENA:  bus_rdata_o[NFLAG-1:0] = st_q.ena;
            ADDR_CFG:  bus_rdata_o[CFG_W-1:0] = st_q.cfg;
            default:   bus_rdata_o = '0;
        endcase
    end

    intagg_pin u_pin (
        .pending_i(pending),
        .cfg_i    (cfg_q),
        .pin_o    (irq_pin_o),
        .oe_o     (irq_oe_o)
    );

endmodule

// File: rtl/intagg_chk.sv
module intagg_chk
    import intagg_pkg::*;
#(
    parameter int NPAIR  = 5,
    parameter int NEDGE  = 6,
    parameter int NPULSE = 10,
    parameter int DW     = 32,
    localparam int NFLAG = 2 * NPAIR + NEDGE + NPULSE,
    localparam int PBASE = 2 * NPAIR + NEDGE
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPAIR-1:0]  lvl_pair_i,
    input logic [NPULSE-1:0] pulse_i,
    input logic [1:0]        bus_addr_i,
    input logic              bus_wr_i,
    input logic [NFLAG-1:0]  flags_q,
    input cfg_t              cfg_q,
    input logic              irq_pin_o,
    input logic              irq_oe_o
);

    // R1: with no clear write, no set flag may drop
    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && bus_addr_i == 2'd1)
        |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R9 / R2: a pulse always leaves its flag set, even against a clear
    a_r9_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i != '0)
        |=> ((flags_q[PBASE +: NPULSE] & $past(pulse_i)) == $past(pulse_i)));

    // R7: a rising paired level leaves its locked flag set
    a_r7_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_pair_i & ~$past(lvl_pair_i)) != '0)
        |=> ((flags_q[NPAIR-1:0] & $past(lvl_pair_i & ~$past(lvl_pair_i)))
             == $past(lvl_pair_i & ~$past(lvl_pair_i))));

    // R4: with the global enable off the pin sits at its idle level
    a_r4_gie_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.gie |-> (irq_pin_o != cfg_q.pol));

    // R6: push-pull always drives
    a_r6_pushpull_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.od |-> irq_oe_o);

    // R6: open-drain drives only the asserted level
    a_r6_od_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.od && irq_oe_o) |-> (irq_pin_o == cfg_q.pol));

endmodule

bind intagg_top intagg_chk #(
    .NPAIR (NPAIR),
    .NEDGE (NEDGE),
    .NPULSE(NPULSE),
    .DW    (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_pair_i(lvl_pair_i),
    .pulse_i   (pulse_i),
    .bus_addr_i(bus_addr_i),
    .bus_wr_i  (bus_wr_i),
    .flags_q   (flags_q),
    .cfg_q     (cfg_q),
    .irq_pin_o (irq_pin_o),
    .irq_oe_o  (irq_oe_o)
);

// File: tb/intagg_top_test.sv
`timescale 1ns/1ps
module intagg_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  lvl_pair = '0;
    logic [5:0]  lvl_edge = '0;
    logic [9:0]  pulse = '0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pin, irq_oe;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    intagg_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_pair_i (lvl_pair),
        .lvl_edge_i (lvl_edge),
        .pulse_i    (pulse),
        .bus_addr_i (bus_addr),
        .bus_wr_i   (bus_wr),
        .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .irq_pin_o  (irq_pin),
        .irq_oe_o   (irq_oe)
    );

    typedef struct packed {
        logic [4:0]  pr;
        logic [5:0]  ed;
        logic [9:0]  pu;
        logic [31:0] clr;
        logic [31:0] exp;
    } vec_t;

    // R7 R8 R9 R1 R2 walked through the table
    localparam vec_t VECS [8] = '{
        '{5'b00001, 6'b000000, 10'h000, 32'h0,        32'h00000001},
        '{5'b00000, 6'b000000, 10'h000, 32'h0,        32'h00000021},
        '{5'b00000, 6'b000001, 10'h000, 32'h1,        32'h00000420},
        '{5'b00000, 6'b000001, 10'h001, 32'h20,       32'h00010400},
        '{5'b00000, 6'b000000, 10'h000, 32'h0,        32'h00010400},
        '{5'b10000, 6'b000000, 10'h000, 32'h00010400, 32'h00000010},
        '{5'b00000, 6'b000000, 10'h200, 32'h10,       32'h02000200},
        '{5'b00000, 6'b000000, 10'h000, 32'hFFFFFFFF, 32'h00000000}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(2'd1, d); chk("R10 flags", d, 32'h0);
        rd(2'd2, d); chk("R10 enables", d, 32'h0);
        rd(2'd3, d); chk("R10 config", d, 32'h0);
        chk("R10 pin idle high", {31'b0, irq_pin}, 32'h1);
        chk("R10 oe", {31'b0, irq_oe}, 32'h1);

        // table walk
        for (int i = 0; i < 8; i++) begin
            lvl_pair = VECS[i].pr;
            lvl_edge = VECS[i].ed;
            pulse    = VECS[i].pu;
            tick();
            pulse = '0;
            wr(2'd1, VECS[i].clr);
            rd(2'd1, d);
            chk($sformatf("R1/R2/R7/R8/R9 vector %0d", i), d, VECS[i].exp);
        end

        // R4: flag set and readable with global enable off, pin idle
        wr(2'd2, 32'h03FFFFFF);
        pulse = 10'h002;
        tick();
        pulse = '0;
        rd(2'd1, d); chk("R4 flag with gie off", d, 32'h00020000);
        chk("R4 pin idle", {31'b0, irq_pin}, 32'h1);

        // R3 R5
        wr(2'd3, 32'h1);
        chk("R3 R5 active low asserted", {31'b0, irq_pin}, 32'h0);
        wr(2'd3, 32'h3);
        chk("R5 active high asserted", {31'b0, irq_pin}, 32'h1);
        wr(2'd2, 32'h0);
        chk("R3 masked deasserted", {31'b0, irq_pin}, 32'h0);

        // R6 open drain
        wr(2'd2, 32'h00020000);
        wr(2'd3, 32'h7);
        chk("R6 od asserted pin", {31'b0, irq_pin}, 32'h1);
        chk("R6 od asserted oe", {31'b0, irq_oe}, 32'h1);
        wr(2'd1, 32'h00020000);
        chk("R6 od released oe", {31'b0, irq_oe}, 32'h0);
        rd(2'd1, d); chk("R2 cleared", d, 32'h0);
        wr(2'd3, 32'h3);
        chk("R6 push-pull oe when idle", {31'b0, irq_oe}, 32'h1);
        chk("R5 idle level active high", {31'b0, irq_pin}, 32'h0);

        // R2 set wins over simultaneous clear
        pulse     = 10'h001;
        bus_addr  = 2'd1;
        bus_wdata = 32'h00010000;
        bus_wr    = 1'b1;
        tick();
        pulse  = '0;
        bus_wr = 1'b0;
        rd(2'd1, d); chk("R2 set wins", d, 32'h00010000);
        wr(2'd1, 32'h00010000);

        // R11 readback
        lvl_pair = 5'b10101;
        lvl_edge = 6'b100001;
        tick();
        rd(2'd0, d); chk("R11 status", d, 32'h00000435);
        rd(2'd2, d); chk("R11 enables", d, 32'h00020000);
        rd(2'd3, d); chk("R11 config", d, 32'h00000003);

        // R10: level high across reset gives a locked edge only
        lvl_pair = 5'b00010;
        lvl_edge = '0;
        rst_n    = 1'b0;
        tick();
        tick();
        rd(2'd1, d); chk("R10 flags in reset", d, 32'h0);
        rst_n = 1'b1;
        tick();
        rd(2'd1, d); chk("R10 lock after reset", d, 32'h00000002);

        finish_run();
    end

endmodule